// File: doc/BRIEF.md
# Two-Channel Bus Switch Selection Target

This block is the control side of a two-way serial bus switch. It watches an I2C bus through a system clock. It cleans up SCL and SDA, finds start and stop conditions, and answers one 7-bit target address. The upper five bits of that address are fixed and the lower two come from strap inputs. Data bytes written to it set which of two downstream channels are connected. A read returns the stored channel choice together with the live state of two active-low interrupt lines, one per channel.

A written selection does not reach the channel-enable outputs at the acknowledge. It waits in the register until the bus shows a stop condition, so that both sides of a channel are idle when the channel connects. A repeated start leaves the pending choice waiting. The block drives SDA only through an open-drain output enable. An asynchronous active-low reset clears the register, the enables and the protocol state.

Top module: `chansel_i2c_target`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits are 1,1,1,0,0 followed by strap_lo[1] and strap_lo[0], with bit 0 as the direction (1 = read, 0 = write). For any other address it leaves SDA released for the acknowledge and for every later byte, until the next start or stop.
- R2: In a write transfer every data byte is acknowledged. When several bytes arrive, the last one is the one that counts.
- R3: Written bit 0 selects channel 0 and bit 1 selects channel 1, independently. Both channels may be on at once, and bits 7:2 have no effect.
- R4: chan_en changes only in the cycle after a stop condition, and then takes the last written selection. A repeated start does not apply a pending selection.
- R5: A read byte carries the stored selection in bits 1:0. Bit 4 is 1 while irq_n[0] is low and bit 5 is 1 while irq_n[1] is low. All other bits read 0.
- R6: In a read, each master ACK produces another copy of the status byte. After a master NACK the block releases SDA.
- R7: While rst_n is low, chan_en is 0 and SDA is released. After reset the stored selection reads back as 0.
- R8: A pulse on SCL shorter than FILT_LEN system clocks is not counted as a clock bit.
- R9: A start condition in the middle of a byte throws away the partial byte and begins a new address phase.
- R10: The block changes its SDA drive only while the filtered SCL is low, except when it releases the line on a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_lo | input | 2 | Pin-strapped low address bits (bit 1 is the higher) |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| irq_n | input | 2 | Active-low interrupt lines, one per channel |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| chan_en | output | 2 | Applied channel enables (bit n enables channel n) |

## Verification
The hardest state to reach from the ports is a selection that has been written and acknowledged but not yet applied. It must then survive a repeated start and a read-back, which already reports the new value, while chan_en still shows the old one. The bench builds this with a bus-level master model: write, repeated start, read with NACK, and only then a stop. It samples chan_en at each step. Filter rejection and mid-transfer recovery are reached the same way. A sub-threshold SCL pulse is injected inside a write, a start is issued after half a byte, and reset is asserted while the target sits in a write.

// File: rtl/chansel_pkg.sv
package chansel_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CHAN_N  = 2;
  localparam int unsigned IRQ_LSB = 4;
  localparam int unsigned CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_IGNORE
  } tgt_state_e;

  function automatic logic [BYTE_W-1:0] pack_status(
    input logic [CHAN_N-1:0] sel,
    input logic [CHAN_N-1:0] pend
  );
    logic [BYTE_W-1:0] v;
    v = '0;
    v[CHAN_N-1:0] = sel;
    v[IRQ_LSB +: CHAN_N] = pend;
    return v;
  endfunction

endpackage

// File: rtl/line_cond.sv
module line_cond #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q,
  output logic rise,
  output logic fall
);

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                filt_q;
  logic                filt_d;
  logic                prev_q;

  always_comb begin
    filt_d = filt_q;
    if (&hist_q) begin
      filt_d = 1'b1;
    end else if (~|hist_q) begin
      filt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      hist_q <= '1;
      filt_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_in};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      filt_q <= filt_d;
      prev_q <= filt_q;
    end
  end

  assign line_q = filt_q;
  assign rise   = filt_q & ~prev_q;
  assign fall   = ~filt_q & prev_q;

  // R8
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> filt_q == $past(hist_q[0]));

endmodule

// File: rtl/target_fsm.sv
module target_fsm
  import chansel_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b11100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_q,
  input  logic                sda_q,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                sda_rise,
  input  logic                sda_fall,
  input  logic [1:0]          strap_lo,
  input  logic [BYTE_W-1:0]   rd_byte,
  output logic                sda_oe,
  output logic                wr_stb,
  output logic [CHAN_N-1:0]   wr_sel,
  output logic                stop_evt
);

  tgt_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic               rw_q, rw_d;
  logic               mack_q, mack_d;
  logic               oe_q, oe_d;
  logic               start_evt;
  logic               addr_hit;

  assign start_evt = sda_fall & scl_q & ~scl_rise;
  assign stop_evt  = sda_rise & scl_q & ~scl_rise;
  assign addr_hit  = (sh_q[BYTE_W-1:1] == {ADDR_HI, strap_lo});

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    wr_stb  = 1'b0;
    if (stop_evt) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_evt) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR_DATA: begin
          if (scl_rise && cnt_q < CNT_W'(BYTE_W)) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_q};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_IGNORE;
              end
            end else begin
              wr_stb  = 1'b1;
              oe_d    = 1'b1;
              state_d = ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              sh_d    = rd_byte;
              oe_d    = ~rd_byte[BYTE_W-1];
              state_d = ST_RD_DATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WR_DATA;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              oe_d    = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_q;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d    = rd_byte;
              oe_d    = ~rd_byte[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_RD_DATA;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe = oe_q;
  assign wr_sel = sh_q[CHAN_N-1:0];

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !stop_evt |=> state_q == ST_ADDR && !oe_q);

  // R1
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IGNORE |-> !oe_q);

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) && !$past(start_evt || stop_evt) |-> !scl_q);

endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import chansel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [CHAN_N-1:0]  wr_sel,
  input  logic               stop_evt,
  input  logic [CHAN_N-1:0]  irq_n,
  output logic [BYTE_W-1:0]  rd_byte,
  output logic [CHAN_N-1:0]  chan_en
);

  logic [CHAN_N-1:0] sel_q, sel_d;
  logic [CHAN_N-1:0] en_q, en_d;
  logic [CHAN_N-1:0] irq_s1_q, irq_s2_q;

  always_comb begin
    sel_d = sel_q;
    en_d  = en_q;
    if (wr_stb) begin
      sel_d = wr_sel;
    end
    if (stop_evt) begin
      en_d = sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      en_q     <= '0;
      irq_s1_q <= '1;
      irq_s2_q <= '1;
    end else begin
      sel_q    <= sel_d;
      en_q     <= en_d;
      irq_s1_q <= irq_n;
      irq_s2_q <= irq_s1_q;
    end
  end

  assign rd_byte = pack_status(sel_q, ~irq_s2_q);
  assign chan_en = en_q;

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_evt |=> $stable(en_q));

  // R4
  en_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> en_q == $past(sel_q));

endmodule

// File: rtl/chansel_i2c_target.sv
module chansel_i2c_target
  import chansel_pkg::*;
#(
  parameter int unsigned FILT_LEN = 3,
  parameter logic [4:0]  ADDR_HI  = 5'b11100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_lo,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [CHAN_N-1:0] irq_n,
  output logic              sda_oe,
  output logic [CHAN_N-1:0] chan_en
);

  localparam int unsigned LINE_N = 2;
  localparam int unsigned SCL_IX = 0;
  localparam int unsigned SDA_IX = 1;

  logic [1:0]          rst_pipe_q;
  logic                rst_sync_n;
  logic [LINE_N-1:0]   raw_lines;
  logic [LINE_N-1:0]   filt_lines;
  logic [LINE_N-1:0]   line_rise;
  logic [LINE_N-1:0]   line_fall;
  logic                wr_stb;
  logic [CHAN_N-1:0]   wr_sel;
  logic                stop_evt;
  logic [BYTE_W-1:0]   rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign raw_lines[SCL_IX] = scl_in;
  assign raw_lines[SDA_IX] = sda_in;

  for (genvar g = 0; g < LINE_N; g++) begin : g_line
    line_cond #(.FILT_LEN(FILT_LEN)) i_line_cond (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .line_in (raw_lines[g]),
      .line_q  (filt_lines[g]),
      .rise    (line_rise[g]),
      .fall    (line_fall[g])
    );
  end

  target_fsm #(.ADDR_HI(ADDR_HI)) i_target_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_q    (filt_lines[SCL_IX]),
    .sda_q    (filt_lines[SDA_IX]),
    .scl_rise (line_rise[SCL_IX]),
    .scl_fall (line_fall[SCL_IX]),
    .sda_rise (line_rise[SDA_IX]),
    .sda_fall (line_fall[SDA_IX]),
    .strap_lo (strap_lo),
    .rd_byte  (rd_byte),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_sel   (wr_sel),
    .stop_evt (stop_evt)
  );

  ctrl_reg i_ctrl_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_stb   (wr_stb),
    .wr_sel   (wr_sel),
    .stop_evt (stop_evt),
    .irq_n    (irq_n),
    .rd_byte  (rd_byte),
    .chan_en  (chan_en)
  );

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (chan_en == '0 && !sda_oe));

endmodule

// File: tb/test_chansel_i2c_target.sv
module test_chansel_i2c_target;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 16;
  localparam int NVEC       = 6;
  localparam logic [7:0] AW = 8'hE4;
  localparam logic [7:0] AR = 8'hE5;

  // {write byte, irq_n, expected chan_en, expected read byte}
  localparam logic [19:0] VEC [NVEC] = '{
    {8'h01, 2'b11, 2'b01, 8'h01},
    {8'h02, 2'b10, 2'b10, 8'h12},
    {8'hFF, 2'b01, 2'b11, 8'h23},
    {8'hFC, 2'b00, 2'b00, 8'h30},
    {8'h03, 2'b11, 2'b11, 8'h03},
    {8'hA6, 2'b00, 2'b10, 8'h32}
  };

  logic       clk;
  logic       rst_n;
  logic [1:0] strap_lo;
  logic       scl_m;
  logic       sda_m;
  logic [1:0] irq_n;
  logic       sda_oe;
  logic [1:0] chan_en;
  logic       sda_line;

  int checks;
  int fails;
  bit done;

  assign sda_line = sda_m & ~sda_oe;

  chansel_i2c_target i_chansel_i2c_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_lo (strap_lo),
    .scl_in   (scl_m),
    .sda_in   (sda_line),
    .irq_n    (irq_n),
    .sda_oe   (sda_oe),
    .chan_en  (chan_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q / 2);
    acked = ~sda_line;
    tick(Q / 2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q / 2);
      b[i] = sda_line;
      tick(Q / 2);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      finish_run();
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rd;
    logic [7:0] rd2;
    logic [7:0] wv;
    logic [1:0] iv;
    logic [1:0] ev;
    logic [7:0] xv;
    checks   = 0;
    fails    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    strap_lo = 2'b10;
    scl_m    = 1'b1;
    sda_m    = 1'b1;
    irq_n    = 2'b11;
    tick(5);
    chk("R7 chan_en in reset", {6'd0, chan_en}, 8'h00);
    chk("R7 sda released in reset", {7'd0, sda_line}, 8'h01);
    rst_n = 1'b1;
    tick(10);
    chk("R7 chan_en after reset", {6'd0, chan_en}, 8'h00);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      wv = VEC[i][19:12];
      iv = VEC[i][11:10];
      ev = VEC[i][9:8];
      xv = VEC[i][7:0];
      bus_start();
      send_byte(AW, ack);
      chk("R1 address ack", {7'd0, ack}, 8'h01);
      send_byte(wv, ack);
      chk("R2 data ack", {7'd0, ack}, 8'h01);
      bus_stop();
      chk("R3 chan_en after stop", {6'd0, chan_en}, {6'd0, ev});
      irq_n = iv;
      tick(8);
      bus_start();
      send_byte(AR, ack);
      recv_byte(1'b0, rd);
      bus_stop();
      chk("R5 read status", rd, xv);
    end
    irq_n = 2'b11;
    tick(8);

    // R4: pending selection survives repeated start
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h03, ack);
    chk("R4 no apply at ack", {6'd0, chan_en}, 8'h02);
    bus_start();
    send_byte(AR, ack);
    recv_byte(1'b0, rd);
    chk("R4 readback of pending", rd, 8'h03);
    chk("R4 no apply at repeated start", {6'd0, chan_en}, 8'h02);
    bus_stop();
    chk("R4 apply at stop", {6'd0, chan_en}, 8'h03);

    // R2: several bytes, last kept
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h01, ack);
    send_byte(8'h03, ack);
    send_byte(8'h02, ack);
    chk("R2 third byte ack", {7'd0, ack}, 8'h01);
    bus_stop();
    chk("R2 last byte kept", {6'd0, chan_en}, 8'h02);

    // R1: address mismatch
    bus_start();
    send_byte(8'hE0, ack);
    chk("R1 wrong high-strap address nack", {7'd0, ack}, 8'h00);
    send_byte(8'h01, ack);
    chk("R1 data ignored after mismatch", {7'd0, ack}, 8'h00);
    bus_stop();
    chk("R1 chan_en unchanged", {6'd0, chan_en}, 8'h02);
    bus_start();
    send_byte(8'hE6, ack);
    chk("R1 wrong low-strap address nack", {7'd0, ack}, 8'h00);
    bus_stop();

    // R8: short SCL pulse inside a write
    bus_start();
    send_byte(AW, ack);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(2);
    scl_m = 1'b0; tick(Q);
    send_byte(8'h01, ack);
    chk("R8 byte ack after glitch", {7'd0, ack}, 8'h01);
    bus_stop();
    chk("R8 glitch not counted", {6'd0, chan_en}, 8'h01);

    // R9: start after half a byte
    bus_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    bus_start();
    send_byte(AW, ack);
    chk("R9 address after restart", {7'd0, ack}, 8'h01);
    send_byte(8'h03, ack);
    bus_stop();
    chk("R9 write after restart", {6'd0, chan_en}, 8'h03);

    // R6: multi-byte read
    irq_n = 2'b01;
    tick(8);
    bus_start();
    send_byte(AR, ack);
    recv_byte(1'b1, rd);
    recv_byte(1'b0, rd2);
    chk("R6 first read byte", rd, 8'h23);
    chk("R6 second read byte", rd2, 8'h23);
    tick(Q);
    chk("R6 sda released after nack", {7'd0, sda_line}, 8'h01);
    bus_stop();
    irq_n = 2'b11;

    // R7: reset during a write
    bus_start();
    send_byte(AW, ack);
    rst_n = 1'b0;
    tick(3);
    chk("R7 chan_en cleared mid-transfer", {6'd0, chan_en}, 8'h00);
    chk("R7 sda released mid-transfer", {7'd0, sda_line}, 8'h01);
    rst_n = 1'b1;
    tick(8);
    bus_stop();
    bus_start();
    send_byte(AR, ack);
    recv_byte(1'b0, rd);
    bus_stop();
    chk("R7 selection zero after reset", rd, 8'h00);
    chk("R7 chan_en zero after stop", {6'd0, chan_en}, 8'h00);

    done = 1'b1;
    finish_run();
  end

endmodule